// File: doc/BRIEF.md
# Reseedable Random Block Controller

This block fronts a seeded pseudo-random generator with a small word-wide register file. Software writes a command word to start either a generate operation, which produces a fresh random block, or a reseed operation, which loads the generator state from an entropy input port. Two busy bits in a status word show which operation is running. The result is held in eight read-only 32-bit words. A configuration bit selects whether all eight words or only the lower four carry data.

Three events are latched as pending flags: result ready, seed finished, and generator stuck at all zeros. Software clears each flag by writing a one to it. A global gate and per-event enables combine the flags into one interrupt line. The block can also reseed itself without a command. One trigger fires after a programmed number of accepted generate requests. The other fires when a free-running age countdown expires. A pending automatic reseed wins over a host generate request that arrives while it waits.

Register offsets: command 0x00, interrupt enable 0x04, pending flags 0x08, status 0x0C, configuration 0x10, auxiliary storage 0x14, request-count reload 0x18, age reload 0x1C, and result words at 0x40 + 4·k for k = 0..7.

Top module: `prng_cmd_ctrl`

## Requirements
- R1: After reset the status, pending and result words all read 0, and `irq` is low.
- R2: Writing 1 to the command word while idle and seeded starts a generate operation. Status bit 30 is high for GEN_CYCLES cycles. The generator is a 32-bit register that steps once per cycle: it shifts left and inserts the XOR of its bits 31, 21, 1 and 0. At the end, result word k holds the value the register had before step GEN_CYCLES-1-k (steps are numbered from 0), all words update together, and pending bit 0 is set.
- R3: Writing 2 to the command word while idle starts a reseed. Status bit 31 is high for SEED_CYCLES cycles. At the end, the generator register is loaded from `seedIn`, pending bit 1 is set, and status bit 9 (seeded) becomes 1 and stays 1.
- R4: A generate command written before the first reseed, or while either busy bit is set, is ignored: no busy bit, pending flag or result word changes. A reseed command written while busy is likewise ignored.
- R5: Pending bits 0, 1 and 4 are each cleared by writing 1 to that bit position. Writing 0 to a bit leaves it unchanged. If a flag is set in the same cycle as its clear, the set wins.
- R6: `irq` is high exactly when enable bit 31 is set and at least one pending bit among 0, 1 and 4 has its enable bit (same position) set.
- R7: Configuration bit 3 set selects 256-bit output, in which all eight result words are valid. When the bit is clear, result words 4 to 7 read 0. Status bit 3 mirrors configuration bit 3.
- R8: A nonzero request-count reload N makes the block reseed automatically after the N-th accepted generate. The reseed starts once that generate has finished. A reload of 0 disables this trigger.
- R9: A nonzero age reload A makes a counter step down once per cycle, except while a reseed runs, and a reseed starts automatically when it reaches 0. A reload of 0 disables this trigger.
- R10: When the generator register becomes all zeros while seeded, pending bit 4 is set. A later reseed from a nonzero `seedIn` restores nonzero output.
- R11: Both automatic counters are loaded from their reload registers only when a reseed finishes. Writing a reload value has no effect until the next reseed completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Byte address of the write |
| wdata | input | 32 | Write data |
| rdAddr | input | 8 | Byte address of the combinational read |
| rdata | output | 32 | Read data for rdAddr |
| seedIn | input | 32 | Entropy word sampled at the end of a reseed |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench builds the block with GEN_CYCLES = 8, SEED_CYCLES = 4 and CNT_W = 8. The generate length is the smallest that still fills all eight words with fresh values, so the word ordering and the effect of the width selection can be checked within a few cycles. With a four-cycle reseed, the age trigger can be timed precisely with a reload of 20: no reseed is expected 10 cycles after loading, and one is expected by 30 cycles. A request reload of 2 or 3 shows the counted trigger, and the loading rule, after only a handful of generates. A model of the shift register in the bench predicts every result word exactly, including the all-zero lockup case.

// File: rtl/prng_pkg.sv
package prng_pkg;
  typedef struct packed {
    logic seedLoad;
    logic genStep;
    logic genCapture;
  } dpCtl_t;

  typedef enum logic [1:0] {S_IDLE, S_GEN, S_SEED} phase_t;

  localparam int RES_WORDS = 8;
  localparam int IDX_W = $clog2(RES_WORDS);

  localparam int EV_RDY = 0;
  localparam int EV_SEED = 1;
  localparam int EV_LOCK = 4;
  localparam int IE_GLOBAL = 31;
  localparam logic [31:0] EV_MASK = 32'h0000_0013;

  localparam int ST_WIDE = 3;
  localparam int ST_SEEDED = 9;
  localparam int ST_GEN = 30;
  localparam int ST_RESEED = 31;

  localparam logic [7:0] A_CMD = 8'h00;
  localparam logic [7:0] A_IEN = 8'h04;
  localparam logic [7:0] A_IPEND = 8'h08;
  localparam logic [7:0] A_STAT = 8'h0C;
  localparam logic [7:0] A_CFG = 8'h10;
  localparam logic [7:0] A_AUX = 8'h14;
  localparam logic [7:0] A_REQ = 8'h18;
  localparam logic [7:0] A_AGE = 8'h1C;
  localparam logic [2:0] A_RES_TOP = 3'b010;

  localparam logic [31:0] CMD_GEN = 32'd1;
  localparam logic [31:0] CMD_SEED = 32'd2;
endpackage

// File: rtl/prng_datapath.sv
module prng_datapath
  import prng_pkg::*;
#(
  parameter logic [31:0] TAPS = 32'h8020_0003
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [31:0]      seedIn,
  input  logic             wide,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [31:0]      rdWord,
  output logic             lfsrZero
);
  localparam logic [IDX_W-1:0] HALF = IDX_W'(RES_WORDS / 2);

  logic [31:0] lfsr;
  logic [31:0] stage [RES_WORDS];
  logic [31:0] res [RES_WORDS];
  logic [31:0] stageNext [RES_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= '0;
    else if (ctl.seedLoad) lfsr <= seedIn;
    else if (ctl.genStep) lfsr <= {lfsr[30:0], ^(lfsr & TAPS)};
  end

  for (genvar gi = 0; gi < RES_WORDS; gi++) begin : g_word
    if (gi == 0) begin : g_head
      assign stageNext[gi] = lfsr;
    end else begin : g_tail
      assign stageNext[gi] = stage[gi-1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage[gi] <= '0;
        res[gi] <= '0;
      end else begin
        if (ctl.genStep) stage[gi] <= stageNext[gi];
        if (ctl.genCapture) res[gi] <= stageNext[gi];
      end
    end
  end

  assign rdWord = (!wide && rdIdx >= HALF) ? '0 : res[rdIdx];
  assign lfsrZero = (lfsr == '0);
endmodule

// File: rtl/prng_ctrl.sv
module prng_ctrl
  import prng_pkg::*;
#(
  parameter int GEN_CYCLES = 16,
  parameter int SEED_CYCLES = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrAddr,
  input  logic [31:0]      wdata,
  input  logic [7:0]       rdAddr,
  output logic [31:0]      rdata,
  input  logic [31:0]      resWord,
  output logic [IDX_W-1:0] rdIdx,
  input  logic             lfsrZero,
  output dpCtl_t           ctl,
  output logic             irq,
  output logic             genBusy,
  output logic             seedBusy,
  output logic             seeded,
  output logic [31:0]      ipend,
  output logic [31:0]      ienable,
  output logic             evRdy
);
  localparam int PH_MAX = (GEN_CYCLES > SEED_CYCLES) ? GEN_CYCLES : SEED_CYCLES;
  localparam int PH_W = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] GEN_LAST = PH_W'(GEN_CYCLES - 1);
  localparam logic [PH_W-1:0] SEED_LAST = PH_W'(SEED_CYCLES - 1);

  phase_t state;
  logic [PH_W-1:0] phase;
  logic modeWide, zeroQ, autoPend;
  logic [31:0] auxReg;
  logic [CNT_W-1:0] reqReload, ageReload, reqCnt, ageCnt;
  logic cmdWr, idle, startSeed, acceptGen, genLast, seedLast, evSeed, evLock;
  logic reqTrig, ageTrig;
  logic [31:0] setVec, clrVec, statusWord;

  assign cmdWr = wrEn && wrAddr == A_CMD;
  assign idle = state == S_IDLE;
  assign genBusy = state == S_GEN;
  assign seedBusy = state == S_SEED;
  assign startSeed = idle && ((cmdWr && wdata == CMD_SEED) || autoPend);
  assign acceptGen = idle && cmdWr && wdata == CMD_GEN && seeded && !autoPend;
  assign genLast = genBusy && phase == GEN_LAST;
  assign seedLast = seedBusy && phase == SEED_LAST;

  assign ctl.genStep = genBusy;
  assign ctl.genCapture = genLast;
  assign ctl.seedLoad = seedLast;

  assign evRdy = genLast;
  assign evSeed = seedLast;
  assign evLock = lfsrZero && !zeroQ && seeded;

  always_comb begin
    setVec = '0;
    setVec[EV_RDY] = evRdy;
    setVec[EV_SEED] = evSeed;
    setVec[EV_LOCK] = evLock;
    clrVec = (wrEn && wrAddr == A_IPEND) ? (wdata & EV_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          phase <= '0;
          if (startSeed) state <= S_SEED;
          else if (acceptGen) state <= S_GEN;
        end
        S_GEN: begin
          phase <= genLast ? '0 : phase + 1'b1;
          if (genLast) state <= S_IDLE;
        end
        S_SEED: begin
          phase <= seedLast ? '0 : phase + 1'b1;
          if (seedLast) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienable <= '0;
      ipend <= '0;
      modeWide <= 1'b0;
      auxReg <= '0;
      reqReload <= '0;
      ageReload <= '0;
      seeded <= 1'b0;
      zeroQ <= 1'b1;
    end else begin
      ipend <= (ipend & ~clrVec) | setVec;
      zeroQ <= lfsrZero;
      if (seedLast) seeded <= 1'b1;
      if (wrEn) begin
        unique case (wrAddr)
          A_IEN: ienable <= wdata;
          A_CFG: modeWide <= wdata[ST_WIDE];
          A_AUX: auxReg <= wdata;
          A_REQ: reqReload <= wdata[CNT_W-1:0];
          A_AGE: ageReload <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign reqTrig = acceptGen && reqCnt == CNT_W'(1);
  assign ageTrig = !seedBusy && ageCnt == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqCnt <= '0;
      ageCnt <= '0;
      autoPend <= 1'b0;
    end else begin
      if (seedLast) begin
        reqCnt <= reqReload;
        ageCnt <= ageReload;
      end else begin
        if (acceptGen && reqCnt != '0) reqCnt <= reqCnt - 1'b1;
        if (!seedBusy && ageCnt != '0) ageCnt <= ageCnt - 1'b1;
      end
      autoPend <= startSeed ? 1'b0 : (autoPend || ((reqTrig || ageTrig) && !seedLast));
    end
  end

  assign irq = ienable[IE_GLOBAL] && |(ienable & ipend & EV_MASK);

  always_comb begin
    statusWord = '0;
    statusWord[ST_RESEED] = seedBusy;
    statusWord[ST_GEN] = genBusy;
    statusWord[ST_SEEDED] = seeded;
    statusWord[ST_WIDE] = modeWide;
  end

  assign rdIdx = rdAddr[IDX_W+1:2];

  always_comb begin
    unique case (rdAddr)
      A_IEN: rdata = ienable;
      A_IPEND: rdata = ipend;
      A_STAT: rdata = statusWord;
      A_CFG: rdata = 32'(modeWide) << ST_WIDE;
      A_AUX: rdata = auxReg;
      A_REQ: rdata = 32'(reqReload);
      A_AGE: rdata = 32'(ageReload);
      default: rdata = (rdAddr[7:5] == A_RES_TOP && rdAddr[1:0] == 2'b00) ? resWord : '0;
    endcase
  end
endmodule

// File: rtl/prng_cmd_ctrl.sv
module prng_cmd_ctrl
  import prng_pkg::*;
#(
  parameter int GEN_CYCLES = 16,
  parameter int SEED_CYCLES = 4,
  parameter int CNT_W = 16,
  parameter logic [31:0] TAPS = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [31:0] wdata,
  input  logic [7:0]  rdAddr,
  output logic [31:0] rdata,
  input  logic [31:0] seedIn,
  output logic        irq
);
  dpCtl_t ctl;
  logic [31:0] resWord, ipend, ienable;
  logic [IDX_W-1:0] rdIdx;
  logic lfsrZero, genBusy, seedBusy, seeded, evRdy, wideSel;

  prng_ctrl #(
    .GEN_CYCLES(GEN_CYCLES),
    .SEED_CYCLES(SEED_CYCLES),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wdata(wdata),
    .rdAddr(rdAddr), .rdata(rdata), .resWord(resWord), .rdIdx(rdIdx),
    .lfsrZero(lfsrZero), .ctl(ctl), .irq(irq), .genBusy(genBusy),
    .seedBusy(seedBusy), .seeded(seeded), .ipend(ipend), .ienable(ienable),
    .evRdy(evRdy)
  );

  prng_datapath #(
    .TAPS(TAPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .seedIn(seedIn), .wide(wideSel),
    .rdIdx(rdIdx), .rdWord(resWord), .lfsrZero(lfsrZero)
  );

  assign wideSel = u_ctrl.modeWide;
endmodule

// File: rtl/prng_cmd_ctrl_chk.sv
module prng_cmd_ctrl_chk
  import prng_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [7:0]  wrAddr,
  input logic [31:0] wdata,
  input logic        irq,
  input logic        genBusy,
  input logic        seedBusy,
  input logic        seeded,
  input logic [31:0] ipend,
  input logic [31:0] ienable,
  input logic        evRdy
);
  // R4
  gen_unseeded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_CMD && wdata == CMD_GEN && !seeded && !seedBusy) |=> !genBusy);

  // R2
  rdy_after_gen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(genBusy) |-> ipend[EV_RDY]);

  // R3
  seed_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seedBusy) |-> (seeded && ipend[EV_SEED]));

  // R3
  seeded_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    seeded |=> seeded);

  // R5
  w1c_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_IPEND && wdata[EV_RDY] && !evRdy) |=> !ipend[EV_RDY]);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ienable[IE_GLOBAL] |-> !irq);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ienable & ipend & EV_MASK) == '0) |-> !irq);
endmodule

bind prng_cmd_ctrl prng_cmd_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wdata(wdata),
  .irq(irq), .genBusy(genBusy), .seedBusy(seedBusy), .seeded(seeded),
  .ipend(ipend), .ienable(ienable), .evRdy(evRdy)
);

// File: tb/prng_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module prng_cmd_ctrl_bench;
  localparam int GEN = 8;
  localparam int SEED = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wdata = '0;
  logic [7:0] rdAddr = '0;
  logic [31:0] rdata;
  logic [31:0] seedIn = '0;
  logic irq;

  int nCmp = 0;
  int nBad = 0;
  logic [31:0] model = '0;
  logic [31:0] words [8];

  typedef struct {
    logic [7:0] addr;
    logic [31:0] mask;
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  prng_cmd_ctrl #(.GEN_CYCLES(GEN), .SEED_CYCLES(SEED), .CNT_W(8)) u_prng_cmd_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wdata(wdata),
    .rdAddr(rdAddr), .rdata(rdata), .seedIn(seedIn), .irq(irq)
  );

  // monitor: pops expected reads and compares
  always @(negedge clk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      rdAddr = it.addr;
      #1;
      nCmp++;
      if ((rdata & it.mask) !== (it.exp & it.mask)) begin
        nBad++;
        $display("FAIL %s: addr %h got %h expected %h", it.tag, it.addr,
                 rdata & it.mask, it.exp & it.mask);
      end
    end
  end

  function automatic logic [31:0] stepOf(logic [31:0] v);
    return {v[30:0], ^(v & 32'h8020_0003)};
  endfunction

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectReg(input logic [7:0] a, input logic [31:0] m,
                           input logic [31:0] e, input string tag);
    q.push_back('{a, m, e, tag});
    do @(negedge clk); while (q.size() != 0);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    nCmp++;
    if (irq !== e) begin
      nBad++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  // advance the bench model of a generate and record the expected words
  task automatic modelGen();
    logic [31:0] hist [GEN];
    for (int j = 0; j < GEN; j++) begin
      hist[j] = model;
      model = stepOf(model);
    end
    for (int k = 0; k < 8; k++) words[k] = hist[GEN-1-k];
  endtask

  task automatic checkWords(input logic wide, input string tag);
    for (int k = 0; k < 8; k++)
      expectReg(8'h40 + 8'(4 * k), 32'hFFFF_FFFF,
                (!wide && k >= 4) ? 32'h0 : words[k], tag);
  endtask

  task automatic doSeed(input logic [31:0] s);
    seedIn = s;
    wrReg(8'h00, 32'd2);
    waitCyc(SEED + 2);
    model = s;
  endtask

  task automatic doGen();
    wrReg(8'h00, 32'd1);
    waitCyc(GEN + 2);
    modelGen();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    expectReg(8'h0C, 32'hFFFF_FFFF, 32'h0, "R1 status");
    expectReg(8'h08, 32'hFFFF_FFFF, 32'h0, "R1 pending");
    expectReg(8'h40, 32'hFFFF_FFFF, 32'h0, "R1 word0");
    checkIrq(1'b0, "R1 irq");

    // R4 generate before seeding is ignored
    wrReg(8'h00, 32'd1);
    expectReg(8'h0C, 32'hFFFF_FFFF, 32'h0, "R4 unseeded status");
    waitCyc(GEN + 2);
    expectReg(8'h08, 32'hFFFF_FFFF, 32'h0, "R4 unseeded pending");
    expectReg(8'h5C, 32'hFFFF_FFFF, 32'h0, "R4 unseeded word7");

    // R3 reseed
    seedIn = 32'h1234_5678;
    wrReg(8'h00, 32'd2);
    expectReg(8'h0C, 32'hC000_0000, 32'h8000_0000, "R3 reseed busy");
    waitCyc(SEED + 2);
    model = 32'h1234_5678;
    expectReg(8'h0C, 32'hFFFF_FFFF, 32'h0000_0200, "R3 seeded status");
    expectReg(8'h08, 32'h13, 32'h02, "R3 seed flag");

    // R5 W1C: clear seed flag, then R7 wide mode
    wrReg(8'h08, 32'h13);
    expectReg(8'h08, 32'hFFFF_FFFF, 32'h0, "R5 clear all");
    wrReg(8'h10, 32'h8);
    expectReg(8'h0C, 32'h8, 32'h8, "R7 status mirrors wide");

    // R2 generate, with R4 commands while busy
    wrReg(8'h00, 32'd1);
    expectReg(8'h0C, 32'hC000_0000, 32'h4000_0000, "R2 generate busy");
    wrReg(8'h00, 32'd1);
    wrReg(8'h00, 32'd2);
    waitCyc(GEN + 2);
    modelGen();
    expectReg(8'h08, 32'h13, 32'h01, "R2 ready flag, R4 busy reseed ignored");
    checkWords(1'b1, "R2 R7 wide words");
    expectReg(8'h0C, 32'hC000_0000, 32'h0, "R4 no late generate");

    // second pattern
    doGen();
    checkWords(1'b1, "R2 second block");

    // R5 selective clear
    doSeed(32'hA5A5_0F0F);
    expectReg(8'h08, 32'h13, 32'h03, "R5 both set");
    wrReg(8'h08, 32'h01);
    expectReg(8'h08, 32'h13, 32'h02, "R5 only bit0 cleared");
    wrReg(8'h08, 32'h00);
    expectReg(8'h08, 32'h13, 32'h02, "R5 zero write no effect");

    // R6 interrupt gating (seed flag pending)
    wrReg(8'h04, 32'h0000_0013);
    checkIrq(1'b0, "R6 no global");
    wrReg(8'h04, 32'h8000_0001);
    checkIrq(1'b0, "R6 pending not enabled");
    wrReg(8'h04, 32'h8000_0002);
    checkIrq(1'b1, "R6 enabled pending");
    wrReg(8'h08, 32'h02);
    checkIrq(1'b0, "R6 cleared");
    wrReg(8'h04, 32'h0);

    // R7 narrow mode
    wrReg(8'h10, 32'h0);
    expectReg(8'h0C, 32'h8, 32'h0, "R7 status narrow");
    doGen();
    checkWords(1'b0, "R7 narrow words");
    wrReg(8'h08, 32'h13);

    // R10 lockup
    doSeed(32'h0);
    waitCyc(2);
    expectReg(8'h08, 32'h13, 32'h12, "R10 lockup flag");
    wrReg(8'h10, 32'h8);
    doGen();
    checkWords(1'b1, "R10 zero output while locked");
    doSeed(32'h0BAD_F00D);
    doGen();
    checkWords(1'b1, "R10 recovered output");
    expectReg(8'h40, 32'hFFFF_FFFF, words[0], "R10 word0 recovered");

    // R11 reload only takes effect after a reseed; R8 request trigger
    wrReg(8'h18, 32'd2);
    wrReg(8'h08, 32'h13);
    doGen();
    doGen();
    doGen();
    expectReg(8'h08, 32'h02, 32'h0, "R11 reload not yet loaded");
    doSeed(32'h5555_AAAB);
    wrReg(8'h08, 32'h13);
    doGen();
    expectReg(8'h08, 32'h02, 32'h0, "R8 first request no reseed");
    wrReg(8'h00, 32'd1);
    waitCyc(GEN + SEED + 6);
    modelGen();
    expectReg(8'h08, 32'h02, 32'h02, "R8 auto reseed after count");
    model = 32'h5555_AAAB;
    doGen();
    checkWords(1'b1, "R8 output after auto reseed");

    // R8 disable, then R9 age trigger
    wrReg(8'h18, 32'd0);
    doSeed(32'h0F0F_1234);
    wrReg(8'h08, 32'h13);
    doGen();
    doGen();
    doGen();
    expectReg(8'h08, 32'h02, 32'h0, "R8 zero reload disables");

    wrReg(8'h1C, 32'd20);
    doSeed(32'h7777_0001);
    wrReg(8'h08, 32'h13);
    waitCyc(8);
    expectReg(8'h08, 32'h02, 32'h0, "R9 age not yet expired");
    waitCyc(22);
    expectReg(8'h08, 32'h02, 32'h02, "R9 age expiry reseeds");
    wrReg(8'h1C, 32'd0);
    waitCyc(30);
    doSeed(32'h7777_0001);
    wrReg(8'h08, 32'h13);
    waitCyc(40);
    expectReg(8'h08, 32'h02, 32'h0, "R9 zero age disables");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule